// File: doc/BRIEF.md
# Address-Mirror ROM Size Detector

This block works out how large an attached ROM is: 1, 2 or 4 MiB. A small ROM that sits in a larger address space shows the same contents again at higher addresses. After a start pulse, the block reads a short run of low addresses. It compares each byte it gets back with the bytes at two candidate mirror offsets, 0x100000 and 0x200000.

Each candidate has its own match counter. A counter moves forward only while every earlier index has matched. Once a candidate has dropped out, the block stops reading at that candidate's offset. The scan ends early when neither candidate can still succeed. When the scan ends, the block reports a size code with a one-cycle done pulse, and the code stays in place until the next scan finishes.

Reads go through a simple request/valid port. The block issues one request at a time and waits for the matching valid before it moves on. The response latency can be any number of cycles, one or more.

Top module: `rom_size_probe`

## Requirements
- R1: A `start` pulse while idle begins a scan and raises `busy`. A `start` while `busy` is high has no effect: it issues no extra reads and produces no extra done pulse.
- R2: The probe window is byte indices 0 to 63. For each index i that the scan visits, the first read goes to address i.
- R3: After the read at i, the block reads 0x100000+i, but only while the 1 MiB counter equals i.
- R4: The block reads 0x200000+i only while the 2 MiB counter equals i. The order for one index is always: base, then 0x100000+i, then 0x200000+i.
- R5: A counter goes up by one when it equals i and the byte read at its mirror offset equals the byte read at i. Otherwise it holds its value. Both counters clear at the start of a scan.
- R6: Before index i is read, the scan ends if neither counter equals i. It also ends after index 63.
- R7: The size code is 2'b00 (1 MiB) if the 1 MiB counter reached 64. Otherwise it is 2'b01 (2 MiB) if the 2 MiB counter reached 64. Otherwise it is 2'b10 (4 MiB). The 1 MiB result wins when both counters reach 64, and the code is never 2'b11.
- R8: `done` is high for exactly one cycle per scan, after the last read's valid. `size_code` changes only in that cycle and holds its value at all other times.
- R9: `rd_req` is high for one cycle per read, with `rd_addr` valid in that cycle. There is at most one read outstanding at a time. `rd_valid` is accepted only while a read is outstanding.
- R10: After reset, `busy`, `done` and `rd_req` are low and `size_code` is 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a scan when idle |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 22 | Byte address of the read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Read data byte |
| busy | output | 1 | A scan is running |
| done | output | 1 | One-cycle end-of-scan pulse |
| size_code | output | 2 | Detected size: 00 = 1 MiB, 01 = 2 MiB, 10 = 4 MiB |

## Verification
The bench covers these corner cases, and what a wrong design would do in each:

- **Mismatch at the last index (63).** The bench drives a 1 MiB image with one corrupted byte at 0x10003F. A design whose window is off by one would still report 1 MiB.
- **Both candidates failing at different indices.** A design with a wrong early-exit test would read on past the point where it should stop, or stop too soon.
- **Both counters reaching 64.** A design that gets the priority wrong would report 2 MiB instead of 1 MiB.
- **Dropped candidate.** After one candidate fails, the bench checks every address in order. A design that keeps probing the dead offset would issue extra reads and show up in that check.
- **Varied read latency and `start` during a scan.** The bench changes the read latency between runs and pulses `start` in the middle of a scan. These expose a design that loses track of its outstanding read or restarts.

// File: rtl/rom_size_probe_pkg.sv
package rom_size_probe_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_EVAL,
    SQ_REQ,
    SQ_WAIT,
    SQ_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_BASE,
    PH_LO,
    PH_HI
  } probe_phase_t;

  localparam logic [1:0] SZ_1M = 2'b00;
  localparam logic [1:0] SZ_2M = 2'b01;
  localparam logic [1:0] SZ_4M = 2'b10;
endpackage

// File: rtl/rsp_match_ctr.sv
module rsp_match_ctr #(
  parameter int CNT_W  = 7,
  parameter int DATA_W = 8,
  parameter int WINDOW = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cmp_en,
  input  logic [CNT_W-1:0]  idx,
  input  logic [DATA_W-1:0] ref_byte,
  input  logic [DATA_W-1:0] probe_byte,
  output logic [CNT_W-1:0]  cnt,
  output logic              live
);
  assign live = (cnt == idx);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cmp_en && live && (probe_byte == ref_byte)) cnt <= cnt + 1'b1;
  end

  // R5: counter bounded by the window
  assert_cnt_in_window_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(WINDOW));

  // R5: a counter only steps by one, or clears
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> ($past(clr) || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/rsp_seq.sv
module rsp_seq
  import rom_size_probe_pkg::*;
#(
  parameter int                ADDR_W   = 22,
  parameter int                DATA_W   = 8,
  parameter int                CNT_W    = 7,
  parameter int                WINDOW   = 64,
  parameter logic [ADDR_W-1:0] OFFS_LO  = 22'h100000,
  parameter logic [ADDR_W-1:0] OFFS_HI  = 22'h200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        live,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  idx,
  output logic [DATA_W-1:0] ref_byte,
  output logic [1:0]        cmp_en,
  output logic              clr,
  output logic              finish,
  output logic              busy
);
  seq_state_t   state;
  probe_phase_t phase;

  logic [ADDR_W-1:0] idx_ext;
  assign idx_ext = ADDR_W'(idx);

  always_comb begin
    unique case (phase)
      PH_LO:   rd_addr = OFFS_LO + idx_ext;
      PH_HI:   rd_addr = OFFS_HI + idx_ext;
      default: rd_addr = idx_ext;
    endcase
  end

  assign rd_req = (state == SQ_REQ);
  assign busy   = (state != SQ_IDLE);
  assign finish = (state == SQ_FIN);
  assign clr    = (state == SQ_IDLE) && start;

  logic take;
  assign take = (state == SQ_WAIT) && rd_valid;
  assign cmp_en[0] = take && (phase == PH_LO);
  assign cmp_en[1] = take && (phase == PH_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      phase    <= PH_BASE;
      idx      <= '0;
      ref_byte <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          idx   <= '0;
          state <= SQ_EVAL;
        end
        SQ_EVAL: begin
          if (idx == CNT_W'(WINDOW) || live == 2'b00) state <= SQ_FIN;
          else begin
            phase <= PH_BASE;
            state <= SQ_REQ;
          end
        end
        SQ_REQ: state <= SQ_WAIT;
        SQ_WAIT: if (rd_valid) begin
          unique case (phase)
            PH_BASE: begin
              ref_byte <= rd_data;
              if (live[0]) begin
                phase <= PH_LO;
                state <= SQ_REQ;
              end else if (live[1]) begin
                phase <= PH_HI;
                state <= SQ_REQ;
              end else begin
                idx   <= idx + 1'b1;
                state <= SQ_EVAL;
              end
            end
            PH_LO: begin
              if (live[1]) begin
                phase <= PH_HI;
                state <= SQ_REQ;
              end else begin
                idx   <= idx + 1'b1;
                state <= SQ_EVAL;
              end
            end
            default: begin
              idx   <= idx + 1'b1;
              state <= SQ_EVAL;
            end
          endcase
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R9: request lasts one cycle
  assert_req_single_R9: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R9: requests only while a scan runs
  assert_req_in_scan_R9: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);

  // R2: base address stays inside the window
  assert_addr_window_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && phase == PH_BASE) |-> (rd_addr < ADDR_W'(WINDOW)));

  // R3: low mirror probed only while its counter is live
  assert_lo_live_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && phase == PH_LO) |-> live[0]);

  // R4: high mirror probed only while its counter is live
  assert_hi_live_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && phase == PH_HI) |-> live[1]);
endmodule

// File: rtl/rom_size_probe.sv
module rom_size_probe
  import rom_size_probe_pkg::*;
#(
  parameter int                ADDR_W  = 22,
  parameter int                DATA_W  = 8,
  parameter int                WINDOW  = 64,
  parameter logic [ADDR_W-1:0] OFFS_LO = 22'h100000,
  parameter logic [ADDR_W-1:0] OFFS_HI = 22'h200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        size_code
);
  localparam int CNT_W = $clog2(WINDOW + 1);

  logic [CNT_W-1:0]  idx;
  logic [DATA_W-1:0] ref_byte;
  logic [1:0]        cmp_en;
  logic [1:0]        live;
  logic              clr;
  logic              finish;
  logic [CNT_W-1:0]  cnt [2];

  rsp_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WINDOW(WINDOW),
    .OFFS_LO(OFFS_LO), .OFFS_HI(OFFS_HI)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .live(live),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .idx(idx), .ref_byte(ref_byte),
    .cmp_en(cmp_en), .clr(clr), .finish(finish), .busy(busy)
  );

  for (genvar g = 0; g < 2; g++) begin : g_cand
    rsp_match_ctr #(.CNT_W(CNT_W), .DATA_W(DATA_W), .WINDOW(WINDOW)) u_ctr (
      .clk(clk), .rst(rst), .clr(clr), .cmp_en(cmp_en[g]), .idx(idx),
      .ref_byte(ref_byte), .probe_byte(rd_data), .cnt(cnt[g]), .live(live[g])
    );
  end

  logic [1:0] size_next;
  always_comb begin
    if (cnt[0] == CNT_W'(WINDOW))      size_next = SZ_1M;
    else if (cnt[1] == CNT_W'(WINDOW)) size_next = SZ_2M;
    else                               size_next = SZ_4M;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      size_code <= SZ_4M;
    end else begin
      done <= finish;
      if (finish) size_code <= size_next;
    end
  end

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: size code moves only with done
  assert_size_held_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(size_code) |-> done);

  // R7: reserved code never reported
  assert_size_legal_R7: assert property (@(posedge clk) disable iff (rst)
    size_code != 2'b11);
endmodule

// File: tb/rom_size_probe_bench.sv
module rom_size_probe_bench;
  localparam int CLK_P = 10;
  localparam logic [21:0] LO = 22'h100000;
  localparam logic [21:0] HI = 22'h200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rd_req, rd_valid = 1'b0, busy, done;
  logic [21:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic [1:0] size_code;

  always #(CLK_P/2) clk = ~clk;

  rom_size_probe u_rom_size_probe (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
    .size_code(size_code)
  );

  int checks = 0, failures = 0, cycles = 0;
  int rom_bytes = 32'h100000;
  logic [21:0] bad_a = '1, bad_b = '1;
  int lat = 1, pend = 0, done_seen = 0;
  logic [21:0] pend_a;
  logic [21:0] exp_q[$];
  logic [1:0] exp_size;

  function automatic logic [7:0] img(input logic [21:0] a);
    logic [21:0] m;
    logic [7:0] v;
    m = a & 22'(rom_bytes - 1);
    v = m[7:0] ^ m[21:14] ^ 8'h5A;
    if (a == bad_a || a == bad_b) v = ~v;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference: expected read order and result from the requirements
  task automatic build_ref();
    int c1 = 0, c2 = 0;
    logic [7:0] b;
    exp_q.delete();
    for (int i = 0; i < 64; i++) begin
      if (c1 != i && c2 != i) break;
      exp_q.push_back(22'(i));
      b = img(22'(i));
      if (c1 == i) begin
        exp_q.push_back(LO + 22'(i));
        if (img(LO + 22'(i)) == b) c1++;
      end
      if (c2 == i) begin
        exp_q.push_back(HI + 22'(i));
        if (img(HI + 22'(i)) == b) c2++;
      end
    end
    exp_size = (c1 == 64) ? 2'b00 : (c2 == 64) ? 2'b01 : 2'b10;
  endtask

  // Per-clock comparison and memory responder
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      rd_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rd_valid = 1'b1;
          rd_data = img(pend_a);
        end
      end
      if (rd_req) begin
        chk(pend == 0 && !rd_valid, "R9 outstanding", pend, 0);
        if (exp_q.size() == 0) chk(0, "R6 extra read", int'(rd_addr), 0);
        else begin
          logic [21:0] e;
          e = exp_q.pop_front();
          chk(rd_addr == e, "R2/R3/R4 read address", int'(rd_addr), int'(e));
        end
        pend_a = rd_addr;
        pend = lat;
      end
      if (done) begin
        done_seen++;
        chk(size_code == exp_size, "R7 size code", size_code, exp_size);
        chk(exp_q.size() == 0, "R6 reads remaining", exp_q.size(), 0);
      end
    end
  end

  task automatic run_case(input int rb, input logic [21:0] ba, input logic [21:0] bb,
                          input int l, input bit poke);
    int d0;
    rom_bytes = rb; bad_a = ba; bad_b = bb; lat = l;
    build_ref();
    d0 = done_seen;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    if (poke) begin
      repeat (7) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (done_seen == d0 && cycles < 150000) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(done_seen == d0 + 1, "R1/R8 single done", done_seen - d0, 1);
    chk(busy == 1'b0 && done == 1'b0, "R8 idle after done", {busy, done}, 0);
    chk(size_code == exp_size, "R8 size held", size_code, exp_size);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && rd_req == 0, "R10 reset outputs", {busy, done, rd_req}, 0);
    chk(size_code == 2'b10, "R10 reset size", size_code, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    // R7 both counters reach 64, 1 MiB wins
    run_case(32'h100000, '1, '1, 1, 0);
    // R3 low candidate drops at index 0, 2 MiB
    run_case(32'h200000, '1, '1, 2, 0);
    // R6 both fail immediately, 4 MiB
    run_case(32'h400000, '1, '1, 3, 0);
    // R5 mismatch at last index 63 on low mirror
    run_case(32'h100000, LO + 22'd63, '1, 1, 0);
    // R6 both fail at index 5
    run_case(32'h100000, LO + 22'd5, HI + 22'd5, 2, 0);
    // R4 high candidate fails later than low
    run_case(32'h200000, HI + 22'd10, '1, 1, 1);
    // R1 start pulsed mid-scan
    run_case(32'h100000, '1, '1, 3, 1);
    if (cycles >= 150000) chk(0, "watchdog", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    chk(0, "watchdog", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule